// File: doc/BRIEF.md
# DSP Indirect Memory Access Port

This block lets a DSP reach external memory through a single data register. The DSP first loads a 32-bit access descriptor: the word address in the upper half and a mode code in the lower half. There is one descriptor for reads and a separate one for writes. Each later read or write through the port runs one transfer on a word-addressed DRAM interface or on a ROM read interface. The mode code picks how the data is written and how the stored address moves after the transfer. The DSP is stalled (`busy`) until the transfer ends.

The write modes cover three cases: a plain store, a store that updates only the nonzero nibbles, and a cell-ordered step. The read modes step the address forward or backward by fixed distances. A family of read modes fetches from banked ROM. After each access a readable mirror shows the descriptor of the port just used, including its stepped address. A mode code that is not recognised does no memory access and reports an error for one cycle.

Top module: `dsp_pm_port`

## Requirements
- R1: A descriptor load (`desc_load`) stores `desc_data` into the write descriptor when `desc_sel`=1 and into the read descriptor when `desc_sel`=0. The address is bits 31:16 and the mode code is bits 15:0. The two descriptors are independent.
- R2: Write mode 0x0018 stores the data word at the descriptor address and leaves the address unchanged. Write mode 0x0818 stores the word and then adds 1 to the address.
- R3: Write mode 0x0418 is an overwrite. It performs one DRAM read and then one DRAM write at the same address. In the written word, each 4-bit nibble takes the data nibble when that nibble is nonzero and keeps the old nibble otherwise. The address does not change.
- R4: Write mode 0x4018 stores the word and write mode 0x4418 overwrites it as in R3. Both then add 31 to the address if it was odd and 1 if it was even.
- R5: Read mode 0x0018 returns the DRAM word with no address change. Read mode 0x0818 adds 1 after the read and read mode 0x3018 adds 32.
- R6: Read mode 0xA818 subtracts 16 after the read and read mode 0xB818 subtracts 128. All address arithmetic wraps modulo 2^16.
- R7: A read mode whose upper 12 bits are 0x080 reads ROM at `rom_addr` = {mode bits 3:0, address}. It then adds 1 to the 16-bit address, and the bank bits do not change.
- R8: When an access completes, `desc_mirror` holds the descriptor of the port just used (the write descriptor for writes), with the address already stepped.
- R9: A mode code not listed in R2 to R7 makes no DRAM or ROM request. It completes with `acc_rdata`=0 and `mode_err` high for exactly that completion cycle.
- R10: A memory request stays asserted with a stable address until its acknowledge. Only one of `dram_req` and `rom_req` is high at a time.
- R11: `busy` is high from the cycle after an access is accepted until completion. `acc_done` rises in the first cycle with `busy` low and carries valid `acc_rdata`. Access requests and descriptor loads made while `busy` is high are ignored. A read request wins over a simultaneous write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_load | input | 1 | Load a descriptor |
| desc_sel | input | 1 | 1 = write descriptor, 0 = read descriptor |
| desc_data | input | 32 | Descriptor value: address in bits 31:16, mode in bits 15:0 |
| desc_mirror | output | 32 | Descriptor of the last port used |
| acc_rd | input | 1 | Read-through-port request |
| acc_wr | input | 1 | Write-through-port request |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid with acc_done |
| acc_done | output | 1 | Access completed (one cycle) |
| mode_err | output | 1 | Unrecognised mode on completed access |
| busy | output | 1 | DSP stall |
| dram_req | output | 1 | DRAM request |
| dram_we | output | 1 | DRAM write enable |
| dram_addr | output | 16 | DRAM word address |
| dram_wdata | output | 16 | DRAM write data |
| dram_ack | input | 1 | DRAM acknowledge |
| dram_rdata | input | 16 | DRAM read data, valid with ack |
| rom_req | output | 1 | ROM read request |
| rom_addr | output | 20 | ROM word address (bank and address) |
| rom_ack | input | 1 | ROM acknowledge |
| rom_rdata | input | 16 | ROM data, valid with ack |

## Verification
The cell step is driven from both an even and an odd address. A design that ignored parity, or tested the wrong bit, would leave the second word at the wrong location. The overwrite mode is checked with a data word that mixes zero and nonzero nibbles. A design that did a plain store, or skipped the read half, would clobber the kept nibbles or show the wrong number of DRAM transfers. The backward read steps are run across zero, so a design with wrong-width arithmetic would show a bad mirror address. The ROM read is run from 0xFFFF, so a design whose carry leaked into the bank bits would show a bad next ROM address. Unknown modes are checked for memory silence and a zero read, and a descriptor load issued while busy is checked to have no effect.

// File: rtl/mport_pkg.sv
package mport_pkg;

   typedef enum logic [1:0] {TGT_NONE, TGT_DRAM, TGT_ROM} tgt_e;

   typedef enum logic [2:0] {
      STP_HOLD, STP_INC1, STP_INC32, STP_DEC16, STP_DEC128, STP_CELL
   } step_e;

   typedef struct packed {
      tgt_e  tgt;
      logic  ovw;
      step_e step;
   } plan_t;

   typedef enum logic [1:0] {ST_IDLE, ST_DRD, ST_DWR, ST_ROM} st_e;

   // write-side mode codes
   localparam logic [15:0] WM_PLAIN    = 16'h0018;
   localparam logic [15:0] WM_INC1     = 16'h0818;
   localparam logic [15:0] WM_OVW      = 16'h0418;
   localparam logic [15:0] WM_CELL     = 16'h4018;
   localparam logic [15:0] WM_OVW_CELL = 16'h4418;
   // read-side mode codes
   localparam logic [15:0] RM_PLAIN    = 16'h0018;
   localparam logic [15:0] RM_INC1     = 16'h0818;
   localparam logic [15:0] RM_INC32    = 16'h3018;
   localparam logic [15:0] RM_DEC16    = 16'ha818;
   localparam logic [15:0] RM_DEC128   = 16'hb818;
   localparam logic [11:0] RM_ROM_PFX  = 12'h080;

endpackage

// File: rtl/mport_decode.sv
module mport_decode
   import mport_pkg::*;
#(
   parameter int MODE_W = 16
) (
   input  logic              is_wr,
   input  logic [MODE_W-1:0] mode,
   output plan_t             plan
);

   if (MODE_W != 16) begin : g_bad_mode_w
      $error("mport_decode: MODE_W must be 16");
   end

   always_comb begin
      plan = '{tgt: TGT_NONE, ovw: 1'b0, step: STP_HOLD};
      if (is_wr) begin
         unique case (mode)
            WM_PLAIN:    plan = '{TGT_DRAM, 1'b0, STP_HOLD};
            WM_INC1:     plan = '{TGT_DRAM, 1'b0, STP_INC1};
            WM_OVW:      plan = '{TGT_DRAM, 1'b1, STP_HOLD};
            WM_CELL:     plan = '{TGT_DRAM, 1'b0, STP_CELL};
            WM_OVW_CELL: plan = '{TGT_DRAM, 1'b1, STP_CELL};
            default:     plan = '{TGT_NONE, 1'b0, STP_HOLD};
         endcase
      end else if (mode[15:4] == RM_ROM_PFX) begin
         plan = '{TGT_ROM, 1'b0, STP_INC1};
      end else begin
         unique case (mode)
            RM_PLAIN:  plan = '{TGT_DRAM, 1'b0, STP_HOLD};
            RM_INC1:   plan = '{TGT_DRAM, 1'b0, STP_INC1};
            RM_INC32:  plan = '{TGT_DRAM, 1'b0, STP_INC32};
            RM_DEC16:  plan = '{TGT_DRAM, 1'b0, STP_DEC16};
            RM_DEC128: plan = '{TGT_DRAM, 1'b0, STP_DEC128};
            default:   plan = '{TGT_NONE, 1'b0, STP_HOLD};
         endcase
      end
   end

endmodule

// File: rtl/mport_step.sv
module mport_step
   import mport_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  step_e             step,
   output logic [ADDR_W-1:0] next
);

   if (ADDR_W < 8) begin : g_bad_addr_w
      $error("mport_step: ADDR_W must be at least 8");
   end

   localparam logic [ADDR_W-1:0] K1   = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] K16  = ADDR_W'(16);
   localparam logic [ADDR_W-1:0] K31  = ADDR_W'(31);
   localparam logic [ADDR_W-1:0] K32  = ADDR_W'(32);
   localparam logic [ADDR_W-1:0] K128 = ADDR_W'(128);

   always_comb begin
      unique case (step)
         STP_INC1:   next = addr + K1;
         STP_INC32:  next = addr + K32;
         STP_DEC16:  next = addr - K16;
         STP_DEC128: next = addr - K128;
         STP_CELL:   next = addr[0] ? addr + K31 : addr + K1;
         default:    next = addr;
      endcase
   end

endmodule

// File: rtl/mport_merge.sv
module mport_merge #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] new_word,
   output logic [DATA_W-1:0] merged
);

   localparam int NIB_N = DATA_W / 4;

   if (DATA_W % 4 != 0) begin : g_bad_data_w
      $error("mport_merge: DATA_W must be a multiple of 4");
   end

   for (genvar n = 0; n < NIB_N; n++) begin : g_nib
      assign merged[4*n +: 4] = (new_word[4*n +: 4] != 4'h0) ? new_word[4*n +: 4]
                                                             : old_word[4*n +: 4];
   end

endmodule

// File: rtl/dsp_pm_port.sv
module dsp_pm_port
   import mport_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int MODE_W = 16,
   parameter int BANK_W = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       desc_load,
   input  logic                       desc_sel,
   input  logic [ADDR_W+MODE_W-1:0]   desc_data,
   output logic [ADDR_W+MODE_W-1:0]   desc_mirror,
   input  logic                       acc_rd,
   input  logic                       acc_wr,
   input  logic [DATA_W-1:0]          acc_wdata,
   output logic [DATA_W-1:0]          acc_rdata,
   output logic                       acc_done,
   output logic                       mode_err,
   output logic                       busy,
   output logic                       dram_req,
   output logic                       dram_we,
   output logic [ADDR_W-1:0]          dram_addr,
   output logic [DATA_W-1:0]          dram_wdata,
   input  logic                       dram_ack,
   input  logic [DATA_W-1:0]          dram_rdata,
   output logic                       rom_req,
   output logic [BANK_W+ADDR_W-1:0]   rom_addr,
   input  logic                       rom_ack,
   input  logic [DATA_W-1:0]          rom_rdata
);

   localparam int DESC_W = ADDR_W + MODE_W;

   if (BANK_W > 4 || BANK_W < 1) begin : g_bad_bank_w
      $error("dsp_pm_port: BANK_W must be 1..4");
   end

   logic [DESC_W-1:0] rd_desc, wr_desc;
   logic              act_wr;
   st_e               st;
   logic [DATA_W-1:0] wbuf;

   plan_t rd_plan, wr_plan, cur_plan;
   logic [DESC_W-1:0] cur_desc;
   logic [ADDR_W-1:0] cur_addr, next_addr;
   logic [MODE_W-1:0] cur_mode;
   logic [DATA_W-1:0] merged;

   mport_decode #(.MODE_W(MODE_W)) u_dec_rd (
      .is_wr(1'b0), .mode(rd_desc[MODE_W-1:0]), .plan(rd_plan));
   mport_decode #(.MODE_W(MODE_W)) u_dec_wr (
      .is_wr(1'b1), .mode(wr_desc[MODE_W-1:0]), .plan(wr_plan));

   assign cur_desc = act_wr ? wr_desc : rd_desc;
   assign cur_plan = act_wr ? wr_plan : rd_plan;
   assign cur_addr = cur_desc[DESC_W-1:MODE_W];
   assign cur_mode = cur_desc[MODE_W-1:0];

   mport_step #(.ADDR_W(ADDR_W)) u_step (
      .addr(cur_addr), .step(cur_plan.step), .next(next_addr));

   mport_merge #(.DATA_W(DATA_W)) u_merge (
      .old_word(dram_rdata), .new_word(wbuf), .merged(merged));

   // memory-side drive
   assign busy       = (st != ST_IDLE);
   assign dram_req   = (st == ST_DRD) || (st == ST_DWR);
   assign dram_we    = (st == ST_DWR);
   assign dram_addr  = cur_addr;
   assign dram_wdata = wbuf;
   assign rom_req    = (st == ST_ROM);
   assign rom_addr   = {cur_mode[BANK_W-1:0], cur_addr};

   // acceptance in idle
   logic  take, take_wr;
   plan_t take_plan;
   assign take      = (st == ST_IDLE) && (acc_rd || acc_wr);
   assign take_wr   = acc_wr && !acc_rd;
   assign take_plan = take_wr ? wr_plan : rd_plan;

   // completion of a real transfer
   logic fin;
   assign fin = ((st == ST_DRD) && dram_ack && !cur_plan.ovw) ||
                ((st == ST_DWR) && dram_ack) ||
                ((st == ST_ROM) && rom_ack);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         act_wr      <= 1'b0;
         rd_desc     <= '0;
         wr_desc     <= '0;
         wbuf        <= '0;
         desc_mirror <= '0;
         acc_rdata   <= '0;
         acc_done    <= 1'b0;
         mode_err    <= 1'b0;
      end else begin
         acc_done <= 1'b0;
         mode_err <= 1'b0;

         if (desc_load && (st == ST_IDLE) && !take) begin
            if (desc_sel) wr_desc <= desc_data;
            else          rd_desc <= desc_data;
         end

         unique case (st)
            ST_IDLE: begin
               if (take) begin
                  act_wr <= take_wr;
                  wbuf   <= acc_wdata;
                  unique case (take_plan.tgt)
                     TGT_DRAM: st <= (take_wr && !take_plan.ovw) ? ST_DWR : ST_DRD;
                     TGT_ROM:  st <= ST_ROM;
                     default: begin
                        acc_rdata   <= '0;
                        acc_done    <= 1'b1;
                        mode_err    <= 1'b1;
                        desc_mirror <= take_wr ? wr_desc : rd_desc;
                     end
                  endcase
               end
            end
            ST_DRD: begin
               if (dram_ack) begin
                  if (cur_plan.ovw) begin
                     wbuf <= merged;
                     st   <= ST_DWR;
                  end else begin
                     acc_rdata <= dram_rdata;
                  end
               end
            end
            ST_ROM: begin
               if (rom_ack) acc_rdata <= rom_rdata;
            end
            default: ;
         endcase

         if (fin) begin
            st          <= ST_IDLE;
            acc_done    <= 1'b1;
            desc_mirror <= {next_addr, cur_mode};
            if (act_wr) wr_desc <= {next_addr, cur_mode};
            else        rd_desc <= {next_addr, cur_mode};
         end
      end
   end

endmodule

// File: rtl/mport_checker.sv
module mport_checker #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int BANK_W = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     busy,
   input logic                     acc_done,
   input logic                     mode_err,
   input logic [DATA_W-1:0]        acc_rdata,
   input logic                     dram_req,
   input logic                     dram_we,
   input logic [ADDR_W-1:0]        dram_addr,
   input logic                     dram_ack,
   input logic                     rom_req,
   input logic [BANK_W+ADDR_W-1:0] rom_addr,
   input logic                     rom_ack
);

   p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(dram_req && rom_req));

   p_dram_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_req && !dram_ack) |=> (dram_req && $stable(dram_addr) && $stable(dram_we)));

   p_rom_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_req && !rom_ack) |=> (rom_req && $stable(rom_addr)));

   p_err_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> (acc_done && !dram_req && !rom_req && acc_rdata == '0));

   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_done |-> !busy);

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!dram_req && !rom_req));

endmodule

bind dsp_pm_port mport_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)
) u_mport_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .acc_done(acc_done),
   .mode_err(mode_err), .acc_rdata(acc_rdata), .dram_req(dram_req),
   .dram_we(dram_we), .dram_addr(dram_addr), .dram_ack(dram_ack),
   .rom_req(rom_req), .rom_addr(rom_addr), .rom_ack(rom_ack)
);

// File: tb/test_dsp_pm_port.sv
module test_dsp_pm_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        desc_load = 1'b0, desc_sel = 1'b0;
   logic [31:0] desc_data = '0;
   logic [31:0] desc_mirror;
   logic        acc_rd = 1'b0, acc_wr = 1'b0;
   logic [15:0] acc_wdata = '0, acc_rdata;
   logic        acc_done, mode_err, busy;
   logic        dram_req, dram_we, dram_ack = 1'b0;
   logic [15:0] dram_addr, dram_wdata, dram_rdata = '0;
   logic        rom_req, rom_ack = 1'b0;
   logic [19:0] rom_addr;
   logic [15:0] rom_rdata = '0;

   always #5 clk = ~clk;

   dsp_pm_port i_dsp_pm_port (
      .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .desc_sel(desc_sel),
      .desc_data(desc_data), .desc_mirror(desc_mirror), .acc_rd(acc_rd),
      .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .acc_done(acc_done), .mode_err(mode_err), .busy(busy),
      .dram_req(dram_req), .dram_we(dram_we), .dram_addr(dram_addr),
      .dram_wdata(dram_wdata), .dram_ack(dram_ack), .dram_rdata(dram_rdata),
      .rom_req(rom_req), .rom_addr(rom_addr), .rom_ack(rom_ack),
      .rom_rdata(rom_rdata));

   // memory models
   logic [15:0] dmem [int];
   int n_drd = 0, n_dwr = 0, n_rom = 0;
   logic [19:0] last_rom = '0;

   function automatic logic [15:0] peek(input int a);
      return dmem.exists(a) ? dmem[a] : 16'h0000;
   endfunction

   function automatic logic [15:0] rom_fn(input logic [19:0] a);
      return a[15:0] ^ {a[19:16], 12'h5a5};
   endfunction

   always @(negedge clk) begin
      if (dram_req && !dram_ack) begin
         dram_ack <= 1'b1;
         if (dram_we) begin dmem[int'(dram_addr)] = dram_wdata; n_dwr++; end
         else begin dram_rdata <= peek(int'(dram_addr)); n_drd++; end
      end else dram_ack <= 1'b0;
      if (rom_req && !rom_ack) begin
         rom_ack   <= 1'b1;
         rom_rdata <= rom_fn(rom_addr);
         last_rom  <= rom_addr;
         n_rom++;
      end else rom_ack <= 1'b0;
   end

   int n_chk = 0, n_fail = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic load_desc(input logic sel, input logic [31:0] v);
      @(negedge clk);
      desc_load = 1'b1; desc_sel = sel; desc_data = v;
      @(negedge clk);
      desc_load = 1'b0;
   endtask

   task automatic wait_done(output logic [15:0] rd, output logic er);
      for (int i = 0; i < 50; i++) begin
         if (acc_done) break;
         @(negedge clk);
      end
      if (!acc_done) chk("R11 completion timeout", 32'd0, 32'd1);
      rd = acc_rdata;
      er = mode_err;
   endtask

   task automatic access(input logic wr, input logic [15:0] wd,
                         output logic [15:0] rd, output logic er);
      @(negedge clk);
      acc_wr = wr; acc_rd = !wr; acc_wdata = wd;
      @(negedge clk);
      acc_wr = 1'b0; acc_rd = 1'b0;
      wait_done(rd, er);
   endtask

   logic [15:0] rd;
   logic        er;

   task automatic t_reset();
      chk("R11 reset busy", 32'(busy), 0);
      chk("R8 reset mirror", desc_mirror, 0);
      chk("R10 reset requests", {dram_req, rom_req}, 0);
      chk("R11 reset done", 32'(acc_done), 0);
   endtask

   task automatic t_plain_write();
      load_desc(1'b1, {16'h0100, 16'h0018});
      access(1'b1, 16'h1234, rd, er);
      chk("R2 plain store", peek(16'h0100), 16'h1234);
      chk("R8 mirror plain write", desc_mirror, 32'h0100_0018);
      load_desc(1'b1, {16'h0200, 16'h0818});
      access(1'b1, 16'haaaa, rd, er);
      access(1'b1, 16'hbbbb, rd, er);
      chk("R2 inc store first", peek(16'h0200), 16'haaaa);
      chk("R2 inc store second", peek(16'h0201), 16'hbbbb);
      chk("R8 mirror inc write", desc_mirror, 32'h0202_0818);
   endtask

   task automatic t_overwrite();
      int r0, w0;
      load_desc(1'b1, {16'h0300, 16'h0018});
      access(1'b1, 16'habcd, rd, er);
      load_desc(1'b1, {16'h0300, 16'h0418});
      r0 = n_drd; w0 = n_dwr;
      access(1'b1, 16'h1020, rd, er);
      chk("R3 nibble merge", peek(16'h0300), 16'h1b2d);
      chk("R3 one read one write", {16'(n_drd - r0), 16'(n_dwr - w0)}, 32'h0001_0001);
      chk("R3 address held", desc_mirror, 32'h0300_0418);
   endtask

   task automatic t_cell();
      load_desc(1'b1, {16'h0040, 16'h4018});
      access(1'b1, 16'h4040, rd, er);
      chk("R4 cell even step", desc_mirror, 32'h0041_4018);
      access(1'b1, 16'h4141, rd, er);
      chk("R4 cell store odd", peek(16'h0041), 16'h4141);
      chk("R4 cell odd step", desc_mirror, 32'h0060_4018);
      load_desc(1'b1, {16'h0061, 16'h0018});
      access(1'b1, 16'h1111, rd, er);
      load_desc(1'b1, {16'h0061, 16'h4418});
      access(1'b1, 16'h0f00, rd, er);
      chk("R4 overwrite cell merge", peek(16'h0061), 16'h1f11);
      chk("R4 overwrite cell step", desc_mirror, 32'h0080_4418);
   endtask

   task automatic t_reads();
      load_desc(1'b0, {16'h0100, 16'h0018});
      access(1'b0, 16'h0, rd, er);
      chk("R5 plain read", rd, 16'h1234);
      chk("R5 plain read no step", desc_mirror, 32'h0100_0018);
      load_desc(1'b0, {16'h0200, 16'h0818});
      access(1'b0, 16'h0, rd, er);
      chk("R5 inc read first", rd, 16'haaaa);
      access(1'b0, 16'h0, rd, er);
      chk("R5 inc read second", rd, 16'hbbbb);
      chk("R5 inc read mirror", desc_mirror, 32'h0202_0818);
      load_desc(1'b0, {16'h0040, 16'h3018});
      access(1'b0, 16'h0, rd, er);
      chk("R5 inc32 data", rd, 16'h4040);
      chk("R5 inc32 step", desc_mirror, 32'h0060_3018);
      load_desc(1'b0, {16'h0010, 16'ha818});
      access(1'b0, 16'h0, rd, er);
      chk("R6 dec16 to zero", desc_mirror, 32'h0000_a818);
      access(1'b0, 16'h0, rd, er);
      chk("R6 dec16 wrap", desc_mirror, 32'hfff0_a818);
      load_desc(1'b0, {16'h0040, 16'hb818});
      access(1'b0, 16'h0, rd, er);
      chk("R6 dec128 data", rd, 16'h4040);
      chk("R6 dec128 wrap", desc_mirror, 32'hffc0_b818);
   endtask

   task automatic t_rom();
      load_desc(1'b0, {16'hffff, 16'h0805});
      access(1'b0, 16'h0, rd, er);
      chk("R7 rom address", 32'(last_rom), 32'h5ffff);
      chk("R7 rom data", rd, rom_fn(20'h5ffff));
      access(1'b0, 16'h0, rd, er);
      chk("R7 rom wrap keeps bank", 32'(last_rom), 32'h50000);
      chk("R7 rom mirror", desc_mirror, 32'h0001_0805);
   endtask

   task automatic t_invalid();
      int r0, w0, q0;
      load_desc(1'b1, {16'h0123, 16'h1234});
      r0 = n_drd; w0 = n_dwr; q0 = n_rom;
      access(1'b1, 16'hdead, rd, er);
      chk("R9 write error flag", 32'(er), 1);
      chk("R9 write no memory", n_drd - r0 + n_dwr - w0 + n_rom - q0, 0);
      load_desc(1'b0, {16'h0456, 16'h0819});
      access(1'b0, 16'h0, rd, er);
      chk("R9 read zero and error", {rd, 15'd0, er}, 32'h0000_0001);
      chk("R9 read no memory", n_drd - r0 + n_dwr - w0 + n_rom - q0, 0);
      chk("R9 mirror unchanged addr", desc_mirror, 32'h0456_0819);
      @(negedge clk);
      chk("R9 error single cycle", 32'(mode_err), 0);
   endtask

   task automatic t_busy_ignore();
      load_desc(1'b0, {16'h0100, 16'h0018});
      load_desc(1'b1, {16'h0300, 16'h0418});
      @(negedge clk);
      acc_wr = 1'b1; acc_wdata = 16'h0005;
      @(negedge clk);
      acc_wr = 1'b0;
      chk("R11 busy during access", 32'(busy), 1);
      desc_load = 1'b1; desc_sel = 1'b0; desc_data = {16'h0200, 16'h0018};
      @(negedge clk);
      desc_load = 1'b0;
      wait_done(rd, er);
      chk("R3 overwrite low nibble", peek(16'h0300), 16'h1b25);
      access(1'b0, 16'h0, rd, er);
      chk("R11 load while busy ignored", rd, 16'h1234);
      chk("R1 descriptors independent", desc_mirror, 32'h0100_0018);
      // simultaneous request: read wins
      @(negedge clk);
      acc_wr = 1'b1; acc_rd = 1'b1; acc_wdata = 16'h9999;
      @(negedge clk);
      acc_wr = 1'b0; acc_rd = 1'b0;
      wait_done(rd, er);
      chk("R11 read priority", rd, 16'h1234);
      chk("R11 write not done", peek(16'h0300), 16'h1b25);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_plain_write();
      t_overwrite();
      t_cell();
      t_reads();
      t_rom();
      t_invalid();
      t_busy_ignore();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk("R11 watchdog expired", 32'd0, 32'd1);
      finish_run();
   end

endmodule